// File: doc/BRIEF.md
# SDRAM Power-Up and Refresh Sequencer

This block sits on the controller side of an SDRAM interface. It takes the memory from reset to a usable state and then keeps its contents alive. After reset it holds the command bus at NOP, with clock enable high and every byte mask high, for a stabilization period. It then precharges all banks and runs a programmable number of auto-refresh cycles. It loads the mode register and raises `ready` once the mode-register delay has passed.

Once ready, an interval counter marks each moment a refresh falls due. A user agent asks for the command bus by holding `usr_req`. The sequencer answers with `usr_grant`, and the grant stays high until the agent drops its request. Refreshes that fall due while the agent holds the bus are counted. They are all issued before the bus is granted again. If more refreshes pile up than the backlog limit allows, a sticky error flag is set. Every delay is given in nanoseconds and converted to clock cycles from the clock-frequency parameter.

Top module: `sdram_init_refresh_seq`

## Requirements
- R1: From reset release until the first precharge, `sd_cke` is 1, every bit of `sd_dqm` is 1, the command is NOP and `ready` is 0. The command is coded as {cs_n,ras_n,cas_n,we_n}, and NOP is 0111.
- R2: No command other than NOP appears for at least STABLE_CYC = ceil(T_STABLE_NS·CLK_MHZ/1000) cycles after reset release. The first other command is precharge (0010) with `sd_addr[10]` = 1, which selects all banks.
- R3: The first auto-refresh (0001) comes exactly RP_CYC = ceil(T_RP_NS·CLK_MHZ/1000) cycles after the precharge.
- R4: Exactly INIT_REFRESHES auto-refreshes precede the mode-register set. Consecutive refreshes are spaced RC_CYC = ceil(T_RC_NS·CLK_MHZ/1000) cycles apart, and the mode-register set follows the last refresh by RC_CYC cycles. NOP is the only command in between.
- R5: The mode-register set (0000) drives MODE_WORD on `sd_addr` and 0 on `sd_ba`.
- R6: `ready` rises exactly T_MRD_CYC cycles after the mode-register set. `sd_dqm` becomes all zeros in the same cycle.
- R7: Once high, `ready` stays high until reset.
- R8: With no user traffic, auto-refreshes are issued every REFI_CYC = floor(T_REFI_NS·CLK_MHZ/1000) cycles. The first one comes REFI_CYC+1 cycles after `ready` rises.
- R9: While idle with no refresh owed, a held `usr_req` gives `usr_grant` = 1 one cycle later. The grant stays high while the request is held and drops one cycle after the request falls. `usr_stall` is high while a request is waiting and not granted. While granted, the sequencer drives NOP.
- R10: Refreshes that fall due during a grant are not issued then. After the release, each one is issued, spaced RC_CYC cycles apart. The next grant comes RC_CYC cycles after the last of them.
- R11: When a refresh falls due while MAX_PENDING are already owed, `refresh_overflow` goes to 1 and stays there until reset.
- R12: When a request and an owed refresh are both present, the refresh is issued first and the requester sees `usr_stall` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| usr_req | input | 1 | User agent asks for and holds the command bus |
| usr_grant | output | 1 | User agent owns the command bus |
| usr_stall | output | 1 | Request waiting, not yet granted |
| sd_cke | output | 1 | Memory clock enable |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | BA_W | Bank address |
| sd_addr | output | ADDR_W | Address; bit 10 selects all banks on precharge |
| sd_dqm | output | DQM_W | Byte masks |
| ready | output | 1 | Initialization complete |
| refresh_overflow | output | 1 | Sticky refresh backlog error |

## Verification
Commands come straight from the state register, so each command appears in the cycle its state is entered. Wait states end one cycle before the next command state, which makes the gaps between precharge, refreshes and mode set exactly RP_CYC, RC_CYC and T_MRD_CYC. A refresh that falls due passes through the interval counter and then the backlog register. It therefore reaches the bus two cycles after the counter expires, which is REFI_CYC+1 cycles after `ready`. The grant is registered and appears one cycle after the request. The bench samples at the falling edge, keeps a cycle counter, and compares each measured gap against these figures derived from the requirements.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

  typedef enum logic [1:0] {
    CMD_NOP,
    CMD_PRE_ALL,
    CMD_REFRESH,
    CMD_MODE_SET
  } seq_cmd_e;

  // Convert nanoseconds to whole cycles, rounding up (minimum delays).
  function automatic int ns_to_cyc_up(input int ns, input int mhz);
    return (ns * mhz + 999) / 1000;
  endfunction

  // Convert nanoseconds to whole cycles, rounding down (maximum intervals).
  function automatic int ns_to_cyc_dn(input int ns, input int mhz);
    return (ns * mhz) / 1000;
  endfunction

  // Timer load value for a command-to-command gap of c cycles,
  // given one issue cycle plus one wait cycle that sees the timer done.
  function automatic int gap_load(input int c);
    return (c > 2) ? c - 2 : 0;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sdram_rst_sync.sv
module sdram_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/sdram_delay_timer.sv
module sdram_delay_timer #(
  parameter int W         = 8,
  parameter int RESET_VAL = 0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         done
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)               cnt_d = load_val;
    else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= W'(RESET_VAL);
    else        cnt_q <= cnt_d;
  end

  assign done = (cnt_q == '0);

  // Once expired and not reloaded, the timer stays expired.
  assert_timer_rest_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !load) |=> done);
endmodule

// File: rtl/sdram_refresh_tick.sv
module sdram_refresh_tick #(
  parameter int REFI_CYC = 1562
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  output logic due
);
  localparam int W = $clog2(REFI_CYC + 1);
  localparam logic [W-1:0] RELOAD = W'(REFI_CYC - 1);

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (!enable)           cnt_d = RELOAD;
    else if (cnt_q == '0)  cnt_d = RELOAD;
    else                   cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= RELOAD;
    else        cnt_q <= cnt_d;
  end

  assign due = enable && (cnt_q == '0);

  generate
    if (REFI_CYC > 1) begin : g_gap_chk
      assert_due_isolated_R8: assert property (@(posedge clk) disable iff (!rst_n)
        due |=> !due);
    end
  endgenerate
endmodule

// File: rtl/sdram_refresh_backlog.sv
module sdram_refresh_backlog #(
  parameter int MAX_PENDING = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic due,
  input  logic served,
  output logic owed,
  output logic overflow
);
  localparam int PW = $clog2(MAX_PENDING + 1);
  localparam logic [PW-1:0] LIMIT = PW'(MAX_PENDING);

  logic [PW-1:0] cnt_q, cnt_d;
  logic          ovf_q, ovf_d;

  always_comb begin
    cnt_d = cnt_q;
    ovf_d = ovf_q;
    if (due && !served) begin
      if (cnt_q == LIMIT) ovf_d = 1'b1;
      else                cnt_d = cnt_q + 1'b1;
    end else if (served && !due) begin
      if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      ovf_q <= ovf_d;
    end
  end

  assign owed     = (cnt_q != '0);
  assign overflow = ovf_q;

  assert_backlog_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LIMIT);
  assert_overflow_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);
  assert_serve_only_owed_R10: assert property (@(posedge clk) disable iff (!rst_n)
    served |-> owed);
endmodule

// File: rtl/sdram_cmd_drive.sv
module sdram_cmd_drive
  import sdram_seq_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int BA_W      = 2,
  parameter int MODE_WORD = 'h022
) (
  input  seq_cmd_e          cmd,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [BA_W-1:0]   ba,
  output logic [ADDR_W-1:0] addr
);
  always_comb begin
    {cs_n, ras_n, cas_n, we_n} = 4'b0111;
    ba   = '0;
    addr = '0;
    unique case (cmd)
      CMD_PRE_ALL: begin
        {cs_n, ras_n, cas_n, we_n} = 4'b0010;
        addr[10] = 1'b1;
      end
      CMD_REFRESH:  {cs_n, ras_n, cas_n, we_n} = 4'b0001;
      CMD_MODE_SET: begin
        {cs_n, ras_n, cas_n, we_n} = 4'b0000;
        addr = ADDR_W'(MODE_WORD);
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/sdram_init_refresh_seq.sv
module sdram_init_refresh_seq
  import sdram_seq_pkg::*;
#(
  parameter int CLK_MHZ        = 100,
  parameter int T_STABLE_NS    = 500000,
  parameter int T_RP_NS        = 20,
  parameter int T_RC_NS        = 70,
  parameter int T_REFI_NS      = 15625,
  parameter int T_MRD_CYC      = 2,
  parameter int INIT_REFRESHES = 8,
  parameter int MAX_PENDING    = 4,
  parameter int ADDR_W         = 12,
  parameter int BA_W           = 2,
  parameter int DQM_W          = 8,
  parameter int MODE_WORD      = 'h022
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              usr_req,
  output logic              usr_grant,
  output logic              usr_stall,
  output logic              sd_cke,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [BA_W-1:0]   sd_ba,
  output logic [ADDR_W-1:0] sd_addr,
  output logic [DQM_W-1:0]  sd_dqm,
  output logic              ready,
  output logic              refresh_overflow
);
  localparam int STABLE_CYC = ns_to_cyc_up(T_STABLE_NS, CLK_MHZ);
  localparam int RP_CYC     = ns_to_cyc_up(T_RP_NS, CLK_MHZ);
  localparam int RC_CYC     = ns_to_cyc_up(T_RC_NS, CLK_MHZ);
  localparam int REFI_CYC   = ns_to_cyc_dn(T_REFI_NS, CLK_MHZ);
  localparam int MAX_WAIT   = max2(max2(STABLE_CYC, RP_CYC), max2(RC_CYC, T_MRD_CYC));
  localparam int TW         = $clog2(MAX_WAIT + 1);
  localparam int IW         = $clog2(INIT_REFRESHES + 1);

  localparam logic [TW-1:0] RP_LOAD  = TW'(gap_load(RP_CYC));
  localparam logic [TW-1:0] RC_LOAD  = TW'(gap_load(RC_CYC));
  localparam logic [TW-1:0] MRD_LOAD = TW'(gap_load(T_MRD_CYC));

  typedef enum logic [3:0] {
    ST_HOLD,
    ST_PREA,
    ST_WAIT_RP,
    ST_INIT_REF,
    ST_WAIT_INIT_RC,
    ST_MODE,
    ST_WAIT_MRD,
    ST_IDLE,
    ST_USER,
    ST_RUN_REF,
    ST_WAIT_RUN_RC
  } seq_state_e;

  logic          rst_s_n;
  seq_state_e    st_q, st_d;
  logic [IW-1:0] left_q, left_d;
  logic          tmr_load, tmr_done;
  logic [TW-1:0] tmr_val;
  logic          ref_due, ref_owed, ref_served;
  seq_cmd_e      cmd;

  sdram_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_s_n)
  );

  sdram_delay_timer #(
    .W         (TW),
    .RESET_VAL (STABLE_CYC)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .done     (tmr_done)
  );

  sdram_refresh_tick #(
    .REFI_CYC (REFI_CYC)
  ) u_tick (
    .clk    (clk),
    .rst_n  (rst_s_n),
    .enable (ready),
    .due    (ref_due)
  );

  sdram_refresh_backlog #(
    .MAX_PENDING (MAX_PENDING)
  ) u_backlog (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .due      (ref_due),
    .served   (ref_served),
    .owed     (ref_owed),
    .overflow (refresh_overflow)
  );

  sdram_cmd_drive #(
    .ADDR_W    (ADDR_W),
    .BA_W      (BA_W),
    .MODE_WORD (MODE_WORD)
  ) u_drive (
    .cmd   (cmd),
    .cs_n  (sd_cs_n),
    .ras_n (sd_ras_n),
    .cas_n (sd_cas_n),
    .we_n  (sd_we_n),
    .ba    (sd_ba),
    .addr  (sd_addr)
  );

  // Next-state and command decode.
  always_comb begin
    st_d       = st_q;
    left_d     = left_q;
    tmr_load   = 1'b0;
    tmr_val    = '0;
    cmd        = CMD_NOP;
    ref_served = 1'b0;
    unique case (st_q)
      ST_HOLD: if (tmr_done) st_d = ST_PREA;
      ST_PREA: begin
        cmd      = CMD_PRE_ALL;
        tmr_load = 1'b1;
        tmr_val  = RP_LOAD;
        st_d     = ST_WAIT_RP;
      end
      ST_WAIT_RP: if (tmr_done) st_d = ST_INIT_REF;
      ST_INIT_REF: begin
        cmd      = CMD_REFRESH;
        tmr_load = 1'b1;
        tmr_val  = RC_LOAD;
        left_d   = left_q - 1'b1;
        st_d     = ST_WAIT_INIT_RC;
      end
      ST_WAIT_INIT_RC: if (tmr_done) st_d = (left_q == '0) ? ST_MODE : ST_INIT_REF;
      ST_MODE: begin
        cmd      = CMD_MODE_SET;
        tmr_load = 1'b1;
        tmr_val  = MRD_LOAD;
        st_d     = ST_WAIT_MRD;
      end
      ST_WAIT_MRD: if (tmr_done) st_d = ST_IDLE;
      ST_IDLE: begin
        if (ref_owed)     st_d = ST_RUN_REF;
        else if (usr_req) st_d = ST_USER;
      end
      ST_USER: if (!usr_req) st_d = ST_IDLE;
      ST_RUN_REF: begin
        cmd        = CMD_REFRESH;
        tmr_load   = 1'b1;
        tmr_val    = RC_LOAD;
        ref_served = 1'b1;
        st_d       = ST_WAIT_RUN_RC;
      end
      ST_WAIT_RUN_RC: begin
        if (tmr_done) begin
          if (ref_owed)     st_d = ST_RUN_REF;
          else if (usr_req) st_d = ST_USER;
          else              st_d = ST_IDLE;
        end
      end
      default: st_d = ST_HOLD;
    endcase
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      st_q   <= ST_HOLD;
      left_q <= IW'(INIT_REFRESHES);
    end else begin
      st_q   <= st_d;
      left_q <= left_d;
    end
  end

  assign ready     = (st_q == ST_IDLE) || (st_q == ST_USER) ||
                     (st_q == ST_RUN_REF) || (st_q == ST_WAIT_RUN_RC);
  assign usr_grant = (st_q == ST_USER);
  assign usr_stall = usr_req && (st_q != ST_USER);
  assign sd_cke    = 1'b1;
  assign sd_dqm    = {DQM_W{~ready}};

  assert_ready_holds_R7: assert property (@(posedge clk) disable iff (!rst_s_n)
    ready |=> ready);
  assert_grant_nop_R9: assert property (@(posedge clk) disable iff (!rst_s_n)
    usr_grant |-> ({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0111));
  assert_grant_stall_excl_R9: assert property (@(posedge clk) disable iff (!rst_s_n)
    !(usr_grant && usr_stall));
  assert_mode_after_refs_R4: assert property (@(posedge clk) disable iff (!rst_s_n)
    (cmd == CMD_MODE_SET) |-> (left_q == '0));
  assert_owed_blocks_grant_R12: assert property (@(posedge clk) disable iff (!rst_s_n)
    (ref_owed && !usr_grant) |=> !$rose(usr_grant));
endmodule

// File: tb/test_sdram_init_refresh_seq.sv
module test_sdram_init_refresh_seq;
  localparam int CLK_MHZ = 200;
  localparam int STABLE  = 1000;   // 5000 ns at 200 MHz
  localparam int RP      = 4;      // 20 ns
  localparam int RC      = 14;     // 70 ns
  localparam int REFI    = 3125;   // 15625 ns
  localparam int MRD     = 2;
  localparam int NREF    = 8;
  localparam int MAXP    = 2;
  localparam logic [11:0] MODE = 12'h022;

  localparam logic [3:0] C_NOP = 4'b0111;
  localparam logic [3:0] C_PRE = 4'b0010;
  localparam logic [3:0] C_REF = 4'b0001;
  localparam logic [3:0] C_MRS = 4'b0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic usr_req = 1'b0;
  logic usr_grant, usr_stall, sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
  logic [1:0]  sd_ba;
  logic [11:0] sd_addr;
  logic [7:0]  sd_dqm;
  logic ready, refresh_overflow;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int c_ready = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sdram_init_refresh_seq #(
    .CLK_MHZ (CLK_MHZ), .T_STABLE_NS (5000), .T_RP_NS (20), .T_RC_NS (70),
    .T_REFI_NS (15625), .T_MRD_CYC (MRD), .INIT_REFRESHES (NREF),
    .MAX_PENDING (MAXP), .ADDR_W (12), .BA_W (2), .DQM_W (8), .MODE_WORD ('h022)
  ) i_sdram_init_refresh_seq (
    .clk (clk), .rst_n (rst_n), .usr_req (usr_req), .usr_grant (usr_grant),
    .usr_stall (usr_stall), .sd_cke (sd_cke), .sd_cs_n (sd_cs_n),
    .sd_ras_n (sd_ras_n), .sd_cas_n (sd_cas_n), .sd_we_n (sd_we_n),
    .sd_ba (sd_ba), .sd_addr (sd_addr), .sd_dqm (sd_dqm), .ready (ready),
    .refresh_overflow (refresh_overflow)
  );

  function automatic logic [3:0] cmd_now();
    return {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  // Step until a refresh command is seen; returns its cycle.
  task automatic wait_ref(output int c);
    c = -1;
    for (int i = 0; i < REFI + 50; i++) begin
      step();
      if (cmd_now() == C_REF) begin c = cyc; break; end
    end
    chk(c >= 0, "R8 refresh seen", c, 0);
  endtask

  task automatic run_until(input int c_end);
    while (cyc < c_end) step();
  endtask

  task automatic test_init();
    int c_rel, c_pre, c_last, c_mrs, nref, hold_err;
    logic [3:0] k;
    step(); step(); step();
    rst_n = 1'b1;
    c_rel = cyc;
    chk(sd_cke == 1'b1, "R1 reset cke", sd_cke, 1);
    chk(sd_dqm == 8'hFF, "R1 reset dqm", sd_dqm, 8'hFF);
    chk(cmd_now() == C_NOP, "R1 reset cmd", cmd_now(), C_NOP);
    chk(ready == 1'b0, "R1 reset ready", ready, 0);
    hold_err = 0;
    for (int i = 0; i < STABLE + 100 && cmd_now() == C_NOP; i++) begin
      step();
      if (cmd_now() == C_NOP && (sd_cke !== 1'b1 || sd_dqm !== 8'hFF || ready !== 1'b0))
        hold_err++;
    end
    chk(hold_err == 0, "R1 hold outputs", hold_err, 0);
    c_pre = cyc;
    chk(c_pre - c_rel >= STABLE, "R2 stable length", c_pre - c_rel, STABLE);
    chk(cmd_now() == C_PRE, "R2 first cmd precharge", cmd_now(), C_PRE);
    chk(sd_addr[10] == 1'b1, "R2 all-bank bit", sd_addr[10], 1);
    step();
    while (cmd_now() == C_NOP && cyc < c_pre + 100) step();
    chk(cmd_now() == C_REF, "R3 refresh after precharge", cmd_now(), C_REF);
    chk(cyc - c_pre == RP, "R3 precharge gap", cyc - c_pre, RP);
    nref = 1;
    c_last = cyc;
    forever begin
      step();
      while (cmd_now() == C_NOP && cyc < c_last + 100) step();
      k = cmd_now();
      if (k != C_REF) break;
      chk(cyc - c_last == RC, "R4 refresh spacing", cyc - c_last, RC);
      nref++;
      c_last = cyc;
    end
    chk(nref == NREF, "R4 refresh count", nref, NREF);
    chk(k == C_MRS, "R5 mode set cmd", k, C_MRS);
    chk(cyc - c_last == RC, "R4 mode set gap", cyc - c_last, RC);
    chk(sd_addr == MODE, "R5 mode word", sd_addr, MODE);
    chk(sd_ba == 2'b00, "R5 bank zero", sd_ba, 0);
    c_mrs = cyc;
    while (!ready && cyc < c_mrs + 50) step();
    chk(cyc - c_mrs == MRD, "R6 ready delay", cyc - c_mrs, MRD);
    chk(sd_dqm == 8'h00, "R6 dqm released", sd_dqm, 0);
    c_ready = cyc;
  endtask

  task automatic test_periodic();
    int c1, c2, drops;
    drops = 0;
    c1 = -1;
    for (int i = 0; i < REFI + 20; i++) begin
      step();
      if (!ready) drops++;
      if (cmd_now() == C_REF) begin c1 = cyc; break; end
    end
    chk(c1 - c_ready == REFI + 1, "R8 first periodic refresh", c1 - c_ready, REFI + 1);
    c2 = -1;
    for (int i = 0; i < REFI + 20; i++) begin
      step();
      if (!ready) drops++;
      if (cmd_now() == C_REF) begin c2 = cyc; break; end
    end
    chk(c2 - c1 == REFI, "R8 refresh interval", c2 - c1, REFI);
    chk(drops == 0, "R7 ready stays high", drops, 0);
  endtask

  task automatic test_grant();
    int x, nop_err;
    wait_ref(x);
    run_until(x + RC + 2);
    usr_req = 1'b1;
    #1;
    chk(usr_stall == 1'b1, "R9 stall before grant", usr_stall, 1);
    chk(usr_grant == 1'b0, "R9 no grant yet", usr_grant, 0);
    step();
    chk(usr_grant == 1'b1, "R9 grant after one cycle", usr_grant, 1);
    chk(usr_stall == 1'b0, "R9 stall cleared", usr_stall, 0);
    nop_err = 0;
    for (int i = 0; i < 20; i++) begin
      step();
      if (!usr_grant || cmd_now() != C_NOP) nop_err++;
    end
    chk(nop_err == 0, "R9 grant held with NOP", nop_err, 0);
    usr_req = 1'b0;
    step();
    chk(usr_grant == 1'b0, "R9 grant released", usr_grant, 0);
  endtask

  task automatic test_backlog();
    int x, nref, c_last, early;
    wait_ref(x);
    run_until(x + RC + 2);
    usr_req = 1'b1;
    step();
    chk(usr_grant == 1'b1, "R10 grant taken", usr_grant, 1);
    early = 0;
    while (cyc < x + 2 * REFI + REFI / 2) begin
      step();
      if (cmd_now() != C_NOP || !usr_grant) early++;
    end
    chk(early == 0, "R10 no refresh while granted", early, 0);
    chk(refresh_overflow == 1'b0, "R11 no overflow at limit", refresh_overflow, 0);
    usr_req = 1'b0;
    step();
    usr_req = 1'b1;
    nref = 0;
    c_last = 0;
    for (int i = 0; i < 200 && !usr_grant; i++) begin
      step();
      if (cmd_now() == C_REF) begin
        if (nref > 0) chk(cyc - c_last == RC, "R10 backlog spacing", cyc - c_last, RC);
        chk(usr_stall == 1'b1, "R12 requester stalled", usr_stall, 1);
        nref++;
        c_last = cyc;
      end
    end
    chk(nref == 2, "R10 owed refreshes served", nref, 2);
    chk(usr_grant == 1'b1 && cyc - c_last == RC, "R12 grant after refreshes",
        cyc - c_last, RC);
    usr_req = 1'b0;
    step();
  endtask

  task automatic test_overflow();
    int x;
    wait_ref(x);
    run_until(x + RC + 2);
    usr_req = 1'b1;
    step();
    run_until(x + 2 * REFI + REFI / 2);
    chk(refresh_overflow == 1'b0, "R11 two owed no flag", refresh_overflow, 0);
    run_until(x + 3 * REFI + REFI / 2);
    chk(refresh_overflow == 1'b1, "R11 flag on third", refresh_overflow, 1);
    usr_req = 1'b0;
    run_until(cyc + 4 * RC + 10);
    chk(refresh_overflow == 1'b1, "R11 flag sticky", refresh_overflow, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    test_init();
    test_periodic();
    test_grant();
    test_backlog();
    test_overflow();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule